// File: doc/BRIEF.md
# Redundant Up/Down Counter with Signed Deferred Carry

This block holds an integer in an N-bit register and accepts an increment pulse or a decrement pulse every clock. A plain binary counter may rewrite every bit on one step. This counter instead trades one bit of range for a bound on how many bits change. A counter of N bits covers values modulo 2^(N-1), and no single operation changes more than three stored bits.

The register has four fields. At the bottom is a Gray-coded pointer ℓ. Above it sit a direction indicator bit and a pending flag. The top field is a plain binary upper word. The indicator and the pointer together form a reflected counter over 2^(LW+1) steps. Any ripple into the upper word is deferred. The flag marks a pending carry when the indicator is 0 and a pending borrow when it is 1. While the flag is set, ℓ also selects which upper bit the next step repairs. An operation in the opposite direction backs out one repair step rather than abandoning the pending correction. A combinational decoder turns the stored word into the plain binary value it stands for.

Top module: `rcnt_updown`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes all zeros, and the decoded value is 0.
- R2: Layout: state[LW-1:0] is the binary-reflected Gray code of ℓ, state[LW] is the indicator I, state[LW+1] is the pending flag S, and state[N-1:LW+2] is the upper word U (width UW = N-LW-2, with UW+1 ≤ 2^LW-1). The pair value P is ℓ when I=0 and 2^(LW+1)-1-ℓ when I=1. The value is P + 2^(LW+1)·((U + c·2^ℓ) mod 2^UW), where c is 0 if S=0, +1 if S=1 and I=0, and −1 if S=1 and I=1. For N=16 and LW=4, 33 increments from reset give state 16'h0041.
- R3: An increment alone raises the decoded value by 1 modulo 2^(N-1).
- R4: A decrement alone lowers the decoded value by 1 modulo 2^(N-1).
- R5: When both inputs or neither are high, the state does not change.
- R6: No operation changes more than 3 state bits.
- R7: An increment with S=0, I=1 and ℓ=0 sets S and clears I, which opens a pending carry. From reset, 32 increments give state 16'h0020.
- R8: A decrement with S=0, I=0 and ℓ=0 sets both S and I, which opens a pending borrow. One decrement from reset gives state 16'h0030.
- R9: An operation against a pending carry or borrow backs out one repair step. When ℓ=0 it closes the pending state and returns the pair to its extreme. So a decrement right after the carry opens gives 16'h0010, and an increment right after the borrow opens gives 16'h0000.
- R10: A pending correction always ends once ℓ passes the top of the upper word. While S=1, ℓ never exceeds UW. Twelve decrements from reset give state 16'hFFDE.
- R11: The value wraps at both ends: one decrement from reset gives 2^(N-1)-1, and the increment that follows gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inc | input | 1 | Increment request for this cycle |
| dec | input | 1 | Decrement request for this cycle |
| state_o | output | N | Stored redundant word |
| value_o | output | N-1 | Decoded binary value |

## Verification
Each operation is applied at a falling edge and takes effect at the next rising edge. The state register and the combinational decoder therefore both show the result one clock after the request. The driver pushes each expected value into a queue when it applies a request. The monitor pops one entry a short delay after each rising edge, so every comparison lands in the cycle the result is due. The same monitor counts state bits that differ from the previous cycle. Directed state checks sample in that same post-edge window, after the one edge that applies their request.

// File: rtl/rcnt_pkg.sv
package rcnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_UP   = 2'b01,
        OP_DOWN = 2'b10
    } rcnt_op_e;

    localparam int unsigned RCNT_MAX_FLIPS = 3;

    function automatic rcnt_op_e rcnt_op_of(input logic up_req, input logic dn_req);
        rcnt_op_e r;
        if (up_req && !dn_req)      r = OP_UP;
        else if (dn_req && !up_req) r = OP_DOWN;
        else                        r = OP_HOLD;
        return r;
    endfunction

endpackage

// File: rtl/rcnt_gray2bin.sv
module rcnt_gray2bin #(
    parameter int W = 4
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    assign bin_o[W-1] = gray_i[W-1];
    for (genvar i = W - 2; i >= 0; i--) begin : g_fold
        assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
    end
endmodule

// File: rtl/rcnt_step.sv
module rcnt_step
    import rcnt_pkg::*;
#(
    parameter int N  = 16,
    parameter int LW = 4
) (
    input  logic [N-1:0]  cur_i,
    input  rcnt_op_e      op_i,
    output logic [N-1:0]  nxt_o,
    output logic [LW-1:0] ptr_o
);
    localparam int UW = N - LW - 2;
    localparam logic [LW-1:0] PTR_MAX = {LW{1'b1}};
    localparam logic [LW-1:0] PTR_ONE = LW'(1);
    localparam logic [LW-1:0] UW_L    = LW'(UW);
    localparam logic [UW-1:0] U_ONE   = UW'(1);

    logic [LW-1:0] ptr_g, ptr, ptr_n;
    logic          ind, flag, ind_n, flag_n;
    logic [UW-1:0] up, up_n, hit_mask, back_mask;
    logic          at_end, hit_set;

    assign ptr_g = cur_i[LW-1:0];
    assign ind   = cur_i[LW];
    assign flag  = cur_i[LW+1];
    assign up    = cur_i[N-1:LW+2];

    rcnt_gray2bin #(.W(LW)) u_g2b (.gray_i(ptr_g), .bin_o(ptr));

    assign hit_mask  = U_ONE << ptr;
    assign back_mask = U_ONE << (ptr - PTR_ONE);
    assign at_end    = (ptr >= UW_L);
    assign hit_set   = |(up & hit_mask);

    always_comb begin
        ptr_n  = ptr;
        ind_n  = ind;
        flag_n = flag;
        up_n   = up;
        unique case (op_i)
            OP_UP: begin
                if (!flag) begin
                    if (!ind) begin
                        if (ptr == PTR_MAX) ind_n = 1'b1;
                        else                ptr_n = ptr + PTR_ONE;
                    end else if (ptr != '0) begin
                        ptr_n = ptr - PTR_ONE;
                    end else begin
                        flag_n = 1'b1;           // open carry
                        ind_n  = 1'b0;
                    end
                end else if (!ind) begin         // carry pending: repair forward
                    ptr_n = ptr + PTR_ONE;
                    if (at_end) begin
                        flag_n = 1'b0;
                    end else if (hit_set) begin
                        up_n = up & ~hit_mask;
                    end else begin
                        up_n   = up | hit_mask;
                        flag_n = 1'b0;
                    end
                end else begin                   // borrow pending: back out
                    if (ptr != '0) begin
                        ptr_n = ptr - PTR_ONE;
                        up_n  = up & ~back_mask;
                    end else begin
                        flag_n = 1'b0;
                        ind_n  = 1'b0;
                    end
                end
            end
            OP_DOWN: begin
                if (!flag) begin
                    if (ind) begin
                        if (ptr == PTR_MAX) ind_n = 1'b0;
                        else                ptr_n = ptr + PTR_ONE;
                    end else if (ptr != '0) begin
                        ptr_n = ptr - PTR_ONE;
                    end else begin
                        flag_n = 1'b1;           // open borrow
                        ind_n  = 1'b1;
                    end
                end else if (ind) begin          // borrow pending: repair forward
                    ptr_n = ptr + PTR_ONE;
                    if (at_end) begin
                        flag_n = 1'b0;
                    end else if (hit_set) begin
                        up_n   = up & ~hit_mask;
                        flag_n = 1'b0;
                    end else begin
                        up_n = up | hit_mask;
                    end
                end else begin                   // carry pending: back out
                    if (ptr != '0) begin
                        ptr_n = ptr - PTR_ONE;
                        up_n  = up | back_mask;
                    end else begin
                        flag_n = 1'b0;
                        ind_n  = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    assign nxt_o = {up_n, flag_n, ind_n, ptr_n ^ (ptr_n >> 1)};
    assign ptr_o = ptr;
endmodule

// File: rtl/rcnt_decode.sv
module rcnt_decode #(
    parameter int N  = 16,
    parameter int LW = 4
) (
    input  logic [N-1:0] st_i,
    output logic [N-2:0] val_o
);
    localparam int UW = N - LW - 2;
    localparam logic [LW:0]   PAIR_TOP = {(LW+1){1'b1}};
    localparam logic [UW-1:0] U_ONE    = UW'(1);

    logic [LW-1:0] ptr;
    logic [LW:0]   pair;
    logic [UW-1:0] up, weight, adj;
    logic          ind, flag;

    assign ind  = st_i[LW];
    assign flag = st_i[LW+1];
    assign up   = st_i[N-1:LW+2];

    rcnt_gray2bin #(.W(LW)) u_g2b (.gray_i(st_i[LW-1:0]), .bin_o(ptr));

    assign weight = U_ONE << ptr;   // zero once ptr leaves the upper word

    always_comb begin
        pair = ind ? (PAIR_TOP - {1'b0, ptr}) : {1'b0, ptr};
        if (!flag)    adj = up;
        else if (ind) adj = up - weight;
        else          adj = up + weight;
    end

    assign val_o = {adj, pair};
endmodule

// File: rtl/rcnt_updown.sv
module rcnt_updown
    import rcnt_pkg::*;
#(
    parameter int N  = 16,
    parameter int LW = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    output logic [N-1:0] state_o,
    output logic [N-2:0] value_o
);
    localparam int UW = N - LW - 2;
    localparam logic [LW-1:0] UW_L = LW'(UW);

    logic [N-1:0]  state_q, state_d;
    logic [LW-1:0] ptr_now;
    rcnt_op_e      op;

    assign op = rcnt_op_of(inc, dec);

    rcnt_step #(.N(N), .LW(LW)) u_step (
        .cur_i (state_q),
        .op_i  (op),
        .nxt_o (state_d),
        .ptr_o (ptr_now)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    rcnt_decode #(.N(N), .LW(LW)) u_dec (
        .st_i  (state_q),
        .val_o (value_o)
    );

    assign state_o = state_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (state_q == '0));

    assert_up_tracks_R3: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec) |=> (value_o == $past(value_o) + 1'b1));

    assert_down_tracks_R4: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc) |=> (value_o == $past(value_o) - 1'b1));

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (inc == dec) |=> $stable(state_q));

    assert_flip_bound_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(state_q ^ $past(state_q)) <= RCNT_MAX_FLIPS));

    assert_ptr_in_range_R10: assert property (@(posedge clk) disable iff (rst)
        state_q[LW+1] |-> (ptr_now <= UW_L));
endmodule

// File: tb/tb_rcnt_updown.sv
module tb_rcnt_updown;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int LW = 4;
    localparam int VW = N - 1;

    typedef struct {
        logic [VW-1:0] val;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inc = 1'b0;
    logic dec = 1'b0;
    logic [N-1:0]  state_o;
    logic [VW-1:0] value_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [VW-1:0] ref_val = '0;
    logic [N-1:0]  prev_state = '0;
    exp_t q[$];

    rcnt_updown #(.N(N), .LW(LW)) dut (
        .clk(clk), .rst(rst), .inc(inc), .dec(dec),
        .state_o(state_o), .value_o(value_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: compares one queued expectation per applied request
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (value_o !== e.val) begin
                    n_fail++;
                    $display("FAIL %s value actual=%0d expected=%0d", e.tag, value_o, e.val);
                end
                n_chk++;
                if ($countones(state_o ^ prev_state) > 3) begin
                    n_fail++;
                    $display("FAIL R6 flipped bits actual=%0d expected<=3",
                             $countones(state_o ^ prev_state));
                end
            end
            prev_state = state_o;
        end
    end

    task automatic step(input logic i, input logic d);
        exp_t e;
        @(negedge clk);
        inc = i;
        dec = d;
        if (i && !d)      begin ref_val = ref_val + 1'b1; e.tag = "R3"; end
        else if (d && !i) begin ref_val = ref_val - 1'b1; e.tag = "R4"; end
        else              e.tag = "R5";
        e.val = ref_val;
        q.push_back(e);
    endtask

    task automatic chk_state(input logic [N-1:0] exp, input string tag);
        @(posedge clk);
        #2;
        n_chk++;
        if (state_o !== exp) begin
            n_fail++;
            $display("FAIL %s state actual=%h expected=%h", tag, state_o, exp);
        end
    endtask

    task automatic chk_value(input logic [VW-1:0] exp, input string tag);
        n_chk++;
        if (value_o !== exp) begin
            n_fail++;
            $display("FAIL %s value actual=%0d expected=%0d", tag, value_o, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        inc = 1'b0;
        dec = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        ref_val = '0;
        n_chk++;
        if (state_o !== '0 || value_o !== '0) begin
            n_fail++;
            $display("FAIL R1 reset actual=%h/%0d expected=0000/0", state_o, value_o);
        end
    endtask

    initial begin
        do_reset();

        // R8 borrow opens; R11 wrap downward
        step(1'b0, 1'b1); chk_state(16'h0030, "R8");
        chk_value(15'h7FFF, "R11");
        // R9 increment backs out the borrow; R11 wrap upward
        step(1'b1, 1'b0); chk_state(16'h0000, "R9");
        chk_value('0, "R11");
        // climb the reflected pair to its top
        for (int k = 0; k < 31; k++) step(1'b1, 1'b0);
        step(1'b0, 1'b0); chk_state(16'h0010, "R2");
        // R7 carry opens
        step(1'b1, 1'b0); chk_state(16'h0020, "R7");
        // R9 decrement backs out the carry
        step(1'b0, 1'b1); chk_state(16'h0010, "R9");
        step(1'b1, 1'b0); chk_state(16'h0020, "R7");
        // R2 first repair step lands in the upper word
        step(1'b1, 1'b0); chk_state(16'h0041, "R2");
        // R5 both and neither hold the state
        step(1'b1, 1'b1); chk_state(16'h0041, "R5");
        step(1'b0, 1'b0); chk_state(16'h0041, "R5");

        // R10 a full borrow ripple ends past the top of the upper word
        do_reset();
        for (int k = 0; k < 11; k++) step(1'b0, 1'b1);
        step(1'b0, 1'b1); chk_state(16'hFFDE, "R10");
        chk_value(15'd32756, "R10");

        // long climb: every carry depth is exercised, value wraps
        do_reset();
        for (int k = 0; k < 33000; k++) step(1'b1, 1'b0);

        // random mix of requests
        for (int k = 0; k < 20000; k++) begin
            int r;
            r = int'($urandom % 8);
            if (r < 3)       step(1'b1, 1'b0);
            else if (r < 6)  step(1'b0, 1'b1);
            else if (r == 6) step(1'b1, 1'b1);
            else             step(1'b0, 1'b0);
        end

        // long descent through zero
        for (int k = 0; k < 5000; k++) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule